// File: doc/BRIEF.md
# Dual-Buffer Paged Flash Store

This block is a synthesizable model of a paged non-volatile store. It sits behind a valid/ready command port. The main array is never written one byte at a time. Every change to a page passes through one of two page-sized RAM buffers. To change part of a page, the user copies the page into a buffer, edits bytes in the buffer, and writes the whole buffer back.

Each page is 264 bytes. Bytes are reached one after another through a cursor, which steps forward after every byte access. The array is split into four equal sectors, and the top two bits of a page number give its sector. Page operations hold a busy flag for a fixed number of cycles, which stands in for the time the cells need. While one buffer is tied to a running page operation, the other buffer stays free for byte traffic.

Top module: `pgflash_store`

## Requirements
- R1: A page holds 264 bytes at offsets 0..263. A seek (opcode 3) with an offset of 264 or more is accepted, raises `cmd_err` for one cycle and leaves every cursor unchanged.
- R2: A buffer write (opcode 0) stores `cmd_data` at the selected buffer's cursor. A buffer read (opcode 1) returns the byte at that cursor on `rd_data`, with `rd_valid` high in the cycle after acceptance. Each of these steps the cursor by one.
- R3: A cursor at 263 wraps to 0 on its next byte access.
- R4: `cmd_buf` picks buffer 0 or 1. Each buffer has its own contents and its own cursor, and traffic to one never alters the other.
- R5: A page-to-buffer transfer (opcode 5) copies the whole page into the selected buffer. `busy` is high for exactly BUSY_CYCLES cycles, starting the cycle after acceptance.
- R6: Erase-and-program (opcode 6) replaces the page with the selected buffer. Page erase (opcode 8) sets every byte of the page to 8'hFF. Both hold `busy` like R5.
- R7: A page counts as erased from reset, or after an erase, until it is next programmed. Program without erase (opcode 7) writes the buffer to an erased page and holds `busy`. On a non-erased page it raises `cmd_err`, leaves the page unchanged and does not raise `busy`.
- R8: While `busy` is high, the array opcodes 2, 5, 6, 7 and 8 see `cmd_ready` low. Byte opcodes (0, 1, 3, 4) aimed at the buffer tied to a running transfer or program also see `cmd_ready` low. The same opcodes aimed at the other buffer are accepted.
- R9: An array read (opcode 2) returns the byte of page `cmd_page` at the array cursor, one cycle after acceptance, and steps that cursor. The array cursor wraps as in R3, and a valid seek sets it together with the buffer cursor.
- R10: For a page operation, `busy_sector` equals the top two bits of its page number, and it holds steady while `busy` is high.
- R11: After reset, every array and buffer byte is 8'hFF and every cursor is 0. `busy`, `rd_valid` and `cmd_err` are low.
- R12: A fill (opcode 4) sets all 264 bytes of the selected buffer to `cmd_data`. Opcodes 9 to 15 are accepted, raise `cmd_err` and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_buf | input | 1 | Buffer select |
| cmd_page | input | $clog2(PAGES) | Page number |
| cmd_off | input | 9 | Byte offset for seek |
| cmd_data | input | 8 | Write or fill byte |
| rd_valid | output | 1 | Read data present |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Page operation in progress |
| busy_sector | output | 2 | Sector of the running page operation |
| cmd_err | output | 1 | One-cycle pulse for a rejected or illegal command |

## Verification
Some properties are checked on every cycle:
- read requests line up with `rd_valid`;
- array commands are refused during `busy`;
- every busy window lasts exactly BUSY_CYCLES cycles and begins only after an accepted page command;
- a rejected program never starts `busy`;
- `busy_sector` stays stable during a window.

Other behaviour can only be shown by the bench's scenarios, which compare outputs against a reference model. This covers byte contents after read-modify-write sequences, cursor wrap-around, independence of the two buffers, and refusal of programs to pages that are not erased. It also covers that the free buffer stays usable during a window and that the full array contents are correct at the end.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
    localparam int          PAGE_BYTES  = 264;
    localparam int          SECTORS     = 4;
    localparam logic [7:0]  BLANK_BYTE  = 8'hFF;

    typedef enum logic [3:0] {
        OP_BWR   = 4'd0,
        OP_BRD   = 4'd1,
        OP_ARD   = 4'd2,
        OP_SEEK  = 4'd3,
        OP_FILL  = 4'd4,
        OP_XFER  = 4'd5,
        OP_PROGE = 4'd6,
        OP_PROG  = 4'd7,
        OP_ERASE = 4'd8
    } op_e;
endpackage

// File: rtl/pgf_pagebuf.sv
// One page-sized RAM buffer with its own byte cursor.
// Assumes the caller asserts at most one of fill/load/wr per cycle.
module pgf_pagebuf
    import pgf_pkg::*;
#(
    parameter int PB = PAGE_BYTES,
    parameter int OW = $clog2(PB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic            seek_en,
    input  logic            fill_en,
    input  logic            load_en,
    input  logic [OW-1:0]   seek_off,
    input  logic [7:0]      din,
    input  logic [PB*8-1:0] load_page,
    output logic [7:0]      dout,
    output logic [PB*8-1:0] page_out
);
    localparam logic [OW-1:0] LAST = OW'(PB - 1);

    logic [7:0]    mem [PB];
    logic [OW-1:0] cur;
    logic [OW-1:0] cur_nx;

    // next cursor position with wrap at the last byte
    always_comb cur_nx = (cur == LAST) ? '0 : cur + 1'b1;

    // buffer contents, cursor and read register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PB; i++) mem[i] <= BLANK_BYTE;
            cur  <= '0;
            dout <= '0;
        end else begin
            if (fill_en) begin
                for (int i = 0; i < PB; i++) mem[i] <= din;
            end else if (load_en) begin
                for (int i = 0; i < PB; i++) mem[i] <= load_page[i*8 +: 8];
            end else if (wr_en) begin
                mem[cur] <= din;
            end
            if (seek_en)            cur <= seek_off;
            else if (wr_en || rd_en) cur <= cur_nx;
            if (rd_en) dout <= mem[cur];
        end
    end

    for (genvar g = 0; g < PB; g++) begin : g_flat
        assign page_out[g*8 +: 8] = mem[g];
    end
endmodule

// File: rtl/pgf_array.sv
// Main page array with per-page erased flags, array read cursor and busy timer.
// Assumes PAGES is a power of two and that erase and program never coincide.
module pgf_array
    import pgf_pkg::*;
#(
    parameter int PAGES       = 8,
    parameter int PB          = PAGE_BYTES,
    parameter int BUSY_CYCLES = 16,
    parameter int PW          = $clog2(PAGES),
    parameter int OW          = $clog2(PB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            prog_en,
    input  logic            erase_en,
    input  logic            rd_en,
    input  logic            seek_en,
    input  logic [OW-1:0]   seek_off,
    input  logic [PW-1:0]   page_sel,
    input  logic [PB*8-1:0] page_in,
    output logic [PB*8-1:0] page_out,
    output logic [7:0]      dout,
    output logic            erased,
    output logic            busy
);
    localparam int AW = $clog2(PAGES * PB);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [OW-1:0] LAST = OW'(PB - 1);

    logic [7:0]    mem [PAGES*PB];
    logic          emap [PAGES];
    logic [CW-1:0] cnt;
    logic [OW-1:0] cur;
    logic [AW-1:0] base_a;

    // byte address of the first byte of the selected page
    always_comb base_a = AW'(page_sel) * AW'(PB);

    // array contents, erased flags, cursor, read register and busy timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES*PB; i++) mem[i] <= BLANK_BYTE;
            for (int p = 0; p < PAGES; p++) emap[p] <= 1'b1;
            cnt  <= '0;
            cur  <= '0;
            dout <= '0;
        end else begin
            if (erase_en) begin
                for (int i = 0; i < PB; i++) mem[base_a + AW'(i)] <= BLANK_BYTE;
                emap[page_sel] <= 1'b1;
            end else if (prog_en) begin
                for (int i = 0; i < PB; i++) mem[base_a + AW'(i)] <= page_in[i*8 +: 8];
                emap[page_sel] <= 1'b0;
            end
            if (start)         cnt <= CW'(BUSY_CYCLES);
            else if (cnt != 0) cnt <= cnt - 1'b1;
            if (seek_en)       cur <= seek_off;
            else if (rd_en)    cur <= (cur == LAST) ? '0 : cur + 1'b1;
            if (rd_en) dout <= mem[base_a + AW'(cur)];
        end
    end

    assign busy   = (cnt != 0);
    assign erased = emap[page_sel];

    for (genvar g = 0; g < PB; g++) begin : g_view
        assign page_out[g*8 +: 8] = mem[base_a + AW'(g)];
    end
endmodule

// File: rtl/pgflash_store.sv
// Top: command decode, acceptance rules, two page buffers and the main array.
// Assumes PAGES is a power of two of at least 4 (four equal sectors).
module pgflash_store
    import pgf_pkg::*;
#(
    parameter int PAGES       = 8,
    parameter int BUSY_CYCLES = 16,
    parameter int PB          = PAGE_BYTES,
    parameter int PW          = $clog2(PAGES),
    parameter int OW          = $clog2(PB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [3:0]    cmd_op,
    input  logic          cmd_buf,
    input  logic [PW-1:0] cmd_page,
    input  logic [OW-1:0] cmd_off,
    input  logic [7:0]    cmd_data,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic [1:0]    busy_sector,
    output logic          cmd_err
);
    localparam int NBUF = 2;
    localparam logic [OW-1:0] LAST = OW'(PB - 1);

    logic            is_arr, is_byte, lock_hit, acc;
    logic            seek_bad, prog_bad, start;
    logic            lock_vld, lock_buf;
    logic            rd_from_arr, rd_buf_q;
    logic            arr_erased;
    logic [7:0]      arr_dout;
    logic [PB*8-1:0] arr_page;
    logic [7:0]      bdout [NBUF];
    logic [PB*8-1:0] bpage [NBUF];

    // classify the opcode and decide acceptance
    always_comb begin
        is_arr  = cmd_op inside {OP_ARD, OP_XFER, OP_PROGE, OP_PROG, OP_ERASE};
        is_byte = cmd_op inside {OP_BWR, OP_BRD, OP_SEEK, OP_FILL};
        lock_hit = busy && lock_vld && (lock_buf == cmd_buf);
        if (is_arr)       cmd_ready = !busy;
        else if (is_byte) cmd_ready = !lock_hit;
        else              cmd_ready = 1'b1;
        acc      = cmd_valid && cmd_ready;
        seek_bad = cmd_off > LAST;
        prog_bad = (cmd_op == OP_PROG) && !arr_erased;
        start    = acc && ((cmd_op inside {OP_XFER, OP_PROGE, OP_ERASE}) ||
                           (cmd_op == OP_PROG && !prog_bad));
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        pgf_pagebuf #(.PB(PB), .OW(OW)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (acc && cmd_op == OP_BWR  && cmd_buf == b[0]),
            .rd_en     (acc && cmd_op == OP_BRD  && cmd_buf == b[0]),
            .seek_en   (acc && cmd_op == OP_SEEK && cmd_buf == b[0] && !seek_bad),
            .fill_en   (acc && cmd_op == OP_FILL && cmd_buf == b[0]),
            .load_en   (acc && cmd_op == OP_XFER && cmd_buf == b[0]),
            .seek_off  (cmd_off),
            .din       (cmd_data),
            .load_page (arr_page),
            .dout      (bdout[b]),
            .page_out  (bpage[b])
        );
    end

    pgf_array #(.PAGES(PAGES), .PB(PB), .BUSY_CYCLES(BUSY_CYCLES), .PW(PW), .OW(OW)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .prog_en  (acc && (cmd_op == OP_PROGE || (cmd_op == OP_PROG && !prog_bad))),
        .erase_en (acc && cmd_op == OP_ERASE),
        .rd_en    (acc && cmd_op == OP_ARD),
        .seek_en  (acc && cmd_op == OP_SEEK && !seek_bad),
        .seek_off (cmd_off),
        .page_sel (cmd_page),
        .page_in  (bpage[cmd_buf]),
        .page_out (arr_page),
        .dout     (arr_dout),
        .erased   (arr_erased),
        .busy     (busy)
    );

    // buffer lock, sector tag, read routing and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_vld    <= 1'b0;
            lock_buf    <= 1'b0;
            busy_sector <= '0;
            rd_valid    <= 1'b0;
            rd_from_arr <= 1'b0;
            rd_buf_q    <= 1'b0;
            cmd_err     <= 1'b0;
        end else begin
            if (start) begin
                lock_vld    <= (cmd_op != OP_ERASE);
                lock_buf    <= cmd_buf;
                busy_sector <= cmd_page[PW-1 -: 2];
            end
            rd_valid    <= acc && (cmd_op == OP_BRD || cmd_op == OP_ARD);
            rd_from_arr <= (cmd_op == OP_ARD);
            rd_buf_q    <= cmd_buf;
            cmd_err     <= acc && ((cmd_op == OP_SEEK && seek_bad) || prog_bad ||
                                   !(is_arr || is_byte));
        end
    end

    assign rd_data = rd_from_arr ? arr_dout : bdout[rd_buf_q];
endmodule

// File: rtl/pgflash_store_chk.sv
// Property checker for pgflash_store, attached through bind.
module pgflash_store_chk #(
    parameter int BUSY_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [3:0] cmd_op,
    input logic       rd_valid,
    input logic       busy,
    input logic [1:0] busy_sector,
    input logic       cmd_err
);
    logic        acc, rd_req, page_req;
    logic [15:0] run;

    always_comb begin
        acc      = cmd_valid && cmd_ready;
        rd_req   = acc && (cmd_op == 4'd1 || cmd_op == 4'd2);
        page_req = acc && (cmd_op inside {4'd5, 4'd6, 4'd7, 4'd8});
    end

    // length of the current busy window so far
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    a_r2_rd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r2_rd_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    a_r8_arr_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && cmd_op inside {4'd2, 4'd5, 4'd6, 4'd7, 4'd8}) |-> !cmd_ready);
    a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run < 16'(BUSY_CYCLES)));
    a_r5_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == 16'(BUSY_CYCLES)));
    a_r6_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(page_req));
    a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !$rose(busy));
    a_r10_sector_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(busy_sector));
endmodule

bind pgflash_store pgflash_store_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .rd_valid    (rd_valid),
    .busy        (busy),
    .busy_sector (busy_sector),
    .cmd_err     (cmd_err)
);

// File: tb/pgflash_store_bench.sv
module pgflash_store_bench;
    localparam int PAGES = 8;
    localparam int BUSY  = 6;
    localparam int PB    = 264;
    localparam int PW    = $clog2(PAGES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [3:0]    cmd_op = '0;
    logic          cmd_buf = 1'b0;
    logic [PW-1:0] cmd_page = '0;
    logic [8:0]    cmd_off = '0;
    logic [7:0]    cmd_data = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          busy;
    logic [1:0]    busy_sector;
    logic          cmd_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] ref_arr [PAGES*PB];
    logic [7:0] ref_buf [2][PB];
    bit         ref_erased [PAGES];
    int         bcur [2];
    int         acur;

    always #10 clk = ~clk;

    pgflash_store #(.PAGES(PAGES), .BUSY_CYCLES(BUSY)) u_pgflash_store (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_buf(cmd_buf), .cmd_page(cmd_page), .cmd_off(cmd_off),
        .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .busy_sector(busy_sector), .cmd_err(cmd_err)
    );

    function automatic void chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endfunction

    function automatic int nxt(int c);
        return (c == PB - 1) ? 0 : c + 1;
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R2";  1: return "R2";  2: return "R9";  3: return "R1";
            4: return "R12"; 5: return "R5";  6: return "R6";  7: return "R7";
            8: return "R6";  default: return "R12";
        endcase
    endfunction

    // issue one command, wait for acceptance, check outputs, advance the model
    task automatic send(input int op, input int b, input int pg, input int off,
                        input int dat, input string tag);
        bit exp_rv = 0, exp_err = 0, exp_busy = 0;
        int exp_rd = 0;
        int base = pg * PB;
        @(negedge clk);
        cmd_op = op[3:0]; cmd_buf = b[0]; cmd_page = pg[PW-1:0];
        cmd_off = off[8:0]; cmd_data = dat[7:0]; cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        case (op)
            0: begin ref_buf[b][bcur[b]] = dat[7:0]; bcur[b] = nxt(bcur[b]); end
            1: begin exp_rv = 1; exp_rd = ref_buf[b][bcur[b]]; bcur[b] = nxt(bcur[b]); end
            2: begin exp_rv = 1; exp_rd = ref_arr[base + acur]; acur = nxt(acur); end
            3: if (off >= PB) exp_err = 1; else begin bcur[b] = off; acur = off; end
            4: for (int i = 0; i < PB; i++) ref_buf[b][i] = dat[7:0];
            5: begin exp_busy = 1; for (int i = 0; i < PB; i++) ref_buf[b][i] = ref_arr[base + i]; end
            6: begin exp_busy = 1; ref_erased[pg] = 0;
                   for (int i = 0; i < PB; i++) ref_arr[base + i] = ref_buf[b][i]; end
            7: if (ref_erased[pg]) begin
                   exp_busy = 1; ref_erased[pg] = 0;
                   for (int i = 0; i < PB; i++) ref_arr[base + i] = ref_buf[b][i];
               end else exp_err = 1;
            8: begin exp_busy = 1; ref_erased[pg] = 1;
                   for (int i = 0; i < PB; i++) ref_arr[base + i] = 8'hFF; end
            default: exp_err = 1;
        endcase
        chk({tag, " rd_valid"}, int'(rd_valid), int'(exp_rv));
        if (exp_rv) chk({tag, " rd_data"}, int'(rd_data), exp_rd);
        chk({tag, " cmd_err"}, int'(cmd_err), int'(exp_err));
        if (op >= 5 && op <= 8) begin
            chk({tag, " busy"}, int'(busy), int'(exp_busy));
            if (exp_busy) chk("R10 busy_sector", int'(busy_sector), pg / (PAGES / 4));
        end
    endtask

    // drive a command for less than a cycle and compare cmd_ready
    task automatic probe(input int op, input int b, input bit exp_rdy, input string tag);
        cmd_op = op[3:0]; cmd_buf = b[0]; cmd_valid = 1'b1;
        #1;
        chk(tag, int'(cmd_ready), int'(exp_rdy));
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd2024));
        for (int i = 0; i < PAGES*PB; i++) ref_arr[i] = 8'hFF;
        for (int i = 0; i < PB; i++) begin ref_buf[0][i] = 8'hFF; ref_buf[1][i] = 8'hFF; end
        for (int p = 0; p < PAGES; p++) ref_erased[p] = 1;
        bcur[0] = 0; bcur[1] = 0; acur = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 rd_valid", int'(rd_valid), 0);
        chk("R11 cmd_err", int'(cmd_err), 0);
        send(2, 0, 3, 0, 0, "R11");
        send(1, 1, 0, 0, 0, "R11");

        // R3: wrap of the buffer cursor, R2 write then read
        send(3, 0, 0, 262, 0, "R3");
        send(0, 0, 0, 0, 8'hAA, "R3");
        send(0, 0, 0, 0, 8'hBB, "R3");
        send(0, 0, 0, 0, 8'hCC, "R3");
        send(3, 0, 0, 262, 0, "R3");
        for (int i = 0; i < 4; i++) send(1, 0, 0, 0, 0, "R3");

        // R1: bad seek keeps cursor; R4: other buffer untouched
        send(3, 0, 0, 300, 0, "R1");
        send(1, 0, 0, 0, 0, "R1");
        send(1, 1, 0, 0, 0, "R4");

        // R12: fill and illegal opcode
        send(4, 1, 0, 0, 8'h5A, "R12");
        send(1, 1, 0, 0, 0, "R12");
        send(12, 1, 0, 0, 0, "R12");
        send(1, 1, 0, 0, 0, "R12");

        // R7: program erased page, refuse second program, erase then retry
        send(7, 0, 2, 0, 0, "R7");
        wait_idle();
        send(7, 1, 2, 0, 0, "R7");
        send(3, 0, 2, 0, 0, "R7");
        send(2, 0, 2, 0, 0, "R7");
        send(8, 0, 2, 0, 0, "R6");
        wait_idle();
        send(7, 1, 2, 0, 0, "R7");
        wait_idle();
        send(6, 0, 2, 0, 0, "R6");
        wait_idle();

        // R5 window length, R8 refusal rules, R10 sector tag
        send(5, 0, 7, 0, 0, "R5");
        cnt = 1;
        probe(2, 0, 0, "R8 array read");
        probe(1, 0, 0, "R8 locked buffer");
        probe(0, 1, 1, "R8 free buffer");
        probe(5, 1, 0, "R8 transfer");
        chk("R10 sector", int'(busy_sector), 3);
        forever begin
            @(negedge clk);
            if (!busy) break;
            cnt++;
        end
        chk("R5 busy length", cnt, BUSY);
        send(5, 1, 1, 0, 0, "R5");
        send(0, 0, 0, 0, 8'h3C, "R8");
        chk("R8 still busy", int'(busy), 1);
        wait_idle();

        // constrained random mix
        for (int k = 0; k < 700; k++) begin
            int r = int'($urandom % 16);
            int op;
            case (r)
                0, 1, 2, 3: op = 0;
                4, 5, 15:   op = 1;
                6, 7:       op = 2;
                8:          op = 3;
                9:          op = 4;
                10:         op = 5;
                11:         op = 6;
                12:         op = 7;
                13:         op = 8;
                default:    op = 9 + int'($urandom % 7);
            endcase
            send(op, int'($urandom % 2), int'($urandom % PAGES),
                 int'($urandom % 300), int'($urandom % 256), tag_of(op));
        end
        wait_idle();

        // R9: full array readback
        for (int p = 0; p < PAGES; p++) begin
            send(3, 0, p, 0, 0, "R9");
            for (int i = 0; i < PB; i++) send(2, 0, p, 0, 0, "R9");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule